// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Generator, Checker and Result Echo

This block adds and verifies the CRC-4 protection of a 2048 kbit/s E1 stream. The stream is organised as a 16-frame multiframe that splits into two 8-frame halves, called submultiframes. An external framer supplies the serial data along with frame, timeslot and bit counters. On the transmit path, the block computes a 4-bit remainder over each submultiframe. It writes that remainder into the first bit of timeslot 0 of the four even frames of the following submultiframe. It also writes the multiframe alignment pattern into the odd frames. On the receive path, the block recomputes the remainder over each incoming submultiframe. It compares the remainder with the check bits that arrive in the next submultiframe and gives a one-clock error pulse for each submultiframe that fails.

The block can also report the receive results back to the far end. With echo on, the most recent pass/fail result of each received half goes out in the spare first bit of timeslot 0 of frame 13 (first half) or frame 15 (second half). Line coding, frame search and signalling are handled elsewhere.

Top module: `e1_crc4_echo`

## Requirements
- R1: With `crc_en`=1, the outgoing bit at `bit_idx`=0, `ts_idx`=0 of frames 0,2,4,6 (and 8,10,12,14) carries C1..C4. These are bits 3..0 of the remainder of x^4·M(x) divided by x^4+x+1. M(x) is the previous submultiframe's 8·TS_PER_FRAME·BITS_PER_TS outgoing bits, taken in order with the C positions replaced by 0.
- R2: With `crc_en`=0, `tx_out` equals `tx_in` at every position, except the frame 13/15 spare bits when `echo_en`=1.
- R3: With `crc_en`=1, the bit at `bit_idx`=0, `ts_idx`=0 of frames 1,3,5,7,9,11 is sent as 0,0,1,0,1,1 in that frame order.
- R4: With `crc_en`=1 and `echo_en`=0, the bit at `bit_idx`=0, `ts_idx`=0 of frames 13 and 15 is sent as 1.
- R5: With `echo_en`=1, frame 13's spare bit carries the latest result for the first half (frames 0–7), and frame 15's spare bit carries the latest result for the second half (frames 8–15). A result is 1 for pass and 0 for fail.
- R6: A received C-bit group that differs from the remainder of the preceding received half raises `rx_err` for exactly one clock, in the cycle after the C4 bit. Bit 0 flags the first half, which is checked at frame 14, and bit 1 flags the second half, which is checked at frame 6.
- R7: The receive check runs whatever the value of `crc_en`.
- R8: No check is made until a full half has been received since reset. Until a transmit remainder exists, C bits are sent as 0. Clearing `crc_en` discards the transmit remainder.
- R9: With `crc_en`=1, all other positions pass `tx_in` through to `tx_out` unchanged and in the same cycle.
- R10: After reset, `rx_err` is 0 and both stored results read as pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Current counters and data bits are valid |
| frame_idx | input | 4 | Frame number in the multiframe, 0–15 |
| ts_idx | input | $clog2(TS_PER_FRAME) | Timeslot number |
| bit_idx | input | $clog2(BITS_PER_TS) | Bit number in timeslot, 0 = first sent |
| crc_en | input | 1 | Enable transmit CRC and alignment insertion |
| echo_en | input | 1 | Send receive results in frames 13 and 15 |
| tx_in | input | 1 | Outgoing data before insertion |
| tx_out | output | 1 | Outgoing data after insertion |
| rx_in | input | 1 | Incoming data |
| rx_err | output | 2 | One-clock mismatch pulse per half |

## Verification
The bench builds the block with TS_PER_FRAME=4 and BITS_PER_TS=8. This gives a 256-bit half and a 512-bit multiframe, so eleven full multiframes fit in a short run. That length makes it possible to cover several echo transitions, a failure detected on one half that appears in the following multiframe, a fail that returns to pass, and the start-up period before the first remainder exists. The receive stream carries correct check bits from an independent long-division model. The bench flips either a payload bit or a C bit to create failures on a chosen half, including while `crc_en` is 0.

// File: rtl/e1crc_pkg.sv
// Package: shared constants, the slot-position record and the CRC-4 step.
// Assumes a 16-frame multiframe made of two 8-frame halves.
package e1crc_pkg;

    localparam int FRAMES_PER_MF = 16;
    localparam int SMF_FRAMES    = 8;
    localparam int CRC_W         = 4;
    // Low terms of x^4 + x + 1; the x^4 term is the shifted-out bit.
    localparam logic [CRC_W-1:0] CRC_POLY_LOW = 4'b0011;

    // Decoded meaning of the current bit position.
    typedef struct packed {
        logic       is_c;       // C-bit position
        logic [1:0] c_idx;      // 0..3 = C1..C4
        logic       smf;        // 0 = frames 0-7, 1 = frames 8-15
        logic       smf_first;  // first bit of a half
        logic       smf_last;   // last bit of a half
        logic       is_mfa;     // multiframe alignment bit
        logic       mfa_val;    // value of that alignment bit
        logic       is_si1;     // spare bit, frame 13
        logic       is_si2;     // spare bit, frame 15
    } e1_slot_t;

    // One serial step of the CRC divider, first bit of the stream first.
    function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] r, input logic d);
        logic fb;
        fb = r[CRC_W-1] ^ d;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY_LOW : '0);
    endfunction

endpackage

// File: rtl/e1crc_slot_decode.sv
// Slot decoder: turns frame/timeslot/bit counters into the position record.
// Assumes the counters come from a framer that is already aligned; bit 0 is the
// first bit sent in a timeslot.
module e1crc_slot_decode
    import e1crc_pkg::*;
#(
    parameter int TS_PER_FRAME = 32,
    parameter int BITS_PER_TS  = 8
) (
    input  logic [3:0]                        frame_idx,
    input  logic [$clog2(TS_PER_FRAME)-1:0]   ts_idx,
    input  logic [$clog2(BITS_PER_TS)-1:0]    bit_idx,
    output e1_slot_t                          slot_o
);

    localparam int TSW = $clog2(TS_PER_FRAME);
    localparam int BW  = $clog2(BITS_PER_TS);
    localparam logic [TSW-1:0] TS_LAST  = TSW'(TS_PER_FRAME - 1);
    localparam logic [BW-1:0]  BIT_LAST = BW'(BITS_PER_TS - 1);

    logic at_head;   // first bit of timeslot 0
    logic at_tail;   // last bit of the last timeslot

    // Purpose: mark the frame head and frame tail positions.
    always_comb begin
        at_head = (ts_idx == '0) && (bit_idx == '0);
        at_tail = (ts_idx == TS_LAST) && (bit_idx == BIT_LAST);
    end

    // Purpose: build the position record from the frame number and the head/tail flags.
    always_comb begin
        slot_o           = '0;
        slot_o.is_c      = at_head && !frame_idx[0];
        slot_o.c_idx     = frame_idx[2:1];
        slot_o.smf       = frame_idx[3];
        slot_o.smf_first = at_head && (frame_idx[2:0] == 3'd0);
        slot_o.smf_last  = at_tail && (frame_idx[2:0] == 3'd7);
        slot_o.is_si1    = at_head && (frame_idx == 4'd13);
        slot_o.is_si2    = at_head && (frame_idx == 4'd15);
        case (frame_idx)
            4'd1, 4'd3, 4'd7: begin slot_o.is_mfa = at_head; slot_o.mfa_val = 1'b0; end
            4'd5, 4'd9, 4'd11: begin slot_o.is_mfa = at_head; slot_o.mfa_val = 1'b1; end
            default:           begin slot_o.is_mfa = 1'b0;    slot_o.mfa_val = 1'b0; end
        endcase
    end

endmodule

// File: rtl/e1crc_accum.sv
// CRC accumulator: runs the CRC-4 divider over one half and latches the
// remainder at the half's last bit. The remainder counts as valid only if the
// whole half was seen from its first bit. A clear discards the validity.
module e1crc_accum
    import e1crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             first,
    input  logic             last,
    input  logic             din,
    output logic [CRC_W-1:0] rem_o,
    output logic             rem_valid_o
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic [CRC_W-1:0] rem_q;
    logic             started_q;
    logic             valid_q;

    // Purpose: next divider state; restart from zero on the first bit of a half.
    always_comb begin
        crc_nxt = crc4_step(first ? '0 : crc_q, din);
    end

    // Purpose: divider, remainder latch and validity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= '0;
            rem_q     <= '0;
            started_q <= 1'b0;
            valid_q   <= 1'b0;
        end else if (clr) begin
            started_q <= 1'b0;
            valid_q   <= 1'b0;
        end else if (en) begin
            crc_q <= crc_nxt;
            if (first) begin
                started_q <= 1'b1;
            end
            if (last) begin
                rem_q   <= crc_nxt;
                valid_q <= started_q || first;
            end
        end
    end

    assign rem_o       = rem_q;
    assign rem_valid_o = valid_q;

    AST_REM_HOLDS_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && last && !clr) |=> $stable(rem_o)); // R1
    AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rem_valid_o) |-> $past(en && last)); // R8

endmodule

// File: rtl/e1crc_tx_insert.sv
// Transmit inserter: chooses the outgoing bit, which is the C bit, the
// alignment bit, the spare/echo bit or the passed-through data bit.
// Purely combinational, so data passes through in the same cycle.
module e1crc_tx_insert
    import e1crc_pkg::*;
(
    input  logic             is_c,
    input  logic [1:0]       c_idx,
    input  logic             is_mfa,
    input  logic             mfa_val,
    input  logic             is_si1,
    input  logic             is_si2,
    input  logic             crc_en,
    input  logic             echo_en,
    input  logic             tx_in,
    input  logic [CRC_W-1:0] rem,
    input  logic             rem_valid,
    input  logic [1:0]       pass,
    output logic             tx_out
);

    // Purpose: select the outgoing bit by position and control state.
    always_comb begin
        tx_out = tx_in;
        if (is_c && crc_en) begin
            tx_out = rem_valid ? rem[2'd3 - c_idx] : 1'b0;
        end else if (is_mfa && crc_en) begin
            tx_out = mfa_val;
        end else if (is_si1 || is_si2) begin
            if (echo_en) begin
                tx_out = is_si1 ? pass[0] : pass[1];
            end else if (crc_en) begin
                tx_out = 1'b1;
            end
        end
    end

endmodule

// File: rtl/e1crc_rx_check.sv
// Receive checker: collects C1..C3 and compares them with C4 against the
// remainder of the preceding half. It pulses an error flag for that half and
// keeps its pass/fail result for echo. Assumes the remainder does not change
// between C1 and C4, which holds because C4 comes before the half ends.
module e1crc_rx_check
    import e1crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             is_c,
    input  logic [1:0]       c_idx,
    input  logic             smf,
    input  logic             rx_in,
    input  logic [CRC_W-1:0] rem,
    input  logic             rem_valid,
    output logic [1:0]       err_o,
    output logic [1:0]       pass_o
);

    logic [2:0]       cbuf_q;
    logic [CRC_W-1:0] recv;
    logic             at_c4;
    logic             chk;
    logic             match;
    logic [1:0]       err_q;
    logic [1:0]       pass_q;

    // Purpose: assemble the received group and find which half it checks.
    always_comb begin
        at_c4 = en && is_c && (c_idx == 2'd3);
        recv  = {cbuf_q, rx_in};
        match = (recv == rem);
        chk   = ~smf;
    end

    // Purpose: shift in C1..C3 as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbuf_q <= '0;
        end else if (en && is_c && (c_idx != 2'd3)) begin
            cbuf_q <= {cbuf_q[1:0], rx_in};
        end
    end

    // Purpose: one-clock error pulse and the stored result for each half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            pass_q <= 2'b11;
        end else begin
            err_q <= '0;
            if (at_c4 && rem_valid) begin
                err_q[chk]  <= !match;
                pass_q[chk] <= match;
            end
        end
    end

    assign err_o  = err_q;
    assign pass_o = pass_q;

    AST_ERR_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_q)); // R6
    AST_ERR_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_q) |=> !(|err_q)); // R6
    AST_FAIL0_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_q[0]) |-> err_q[0]); // R5
    AST_FAIL1_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_q[1]) |-> err_q[1]); // R5
    AST_CHECK_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_q) |-> $past(rem_valid)); // R8

endmodule

// File: rtl/e1_crc4_echo.sv
// Top: E1 CRC-4 generator and checker with optional result echo.
// Assumes externally supplied counters that follow the multiframe. The
// transmit CRC runs over the block's own output with the C positions taken
// as 0. The receive CRC always runs.
module e1_crc4_echo
    import e1crc_pkg::*;
#(
    parameter int TS_PER_FRAME = 32,
    parameter int BITS_PER_TS  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_en,
    input  logic [3:0]                        frame_idx,
    input  logic [$clog2(TS_PER_FRAME)-1:0]   ts_idx,
    input  logic [$clog2(BITS_PER_TS)-1:0]    bit_idx,
    input  logic                              crc_en,
    input  logic                              echo_en,
    input  logic                              tx_in,
    output logic                              tx_out,
    input  logic                              rx_in,
    output logic [1:0]                        rx_err
);

    e1_slot_t         slot;
    logic [CRC_W-1:0] tx_rem;
    logic             tx_rem_valid;
    logic [CRC_W-1:0] rx_rem;
    logic             rx_rem_valid;
    logic [1:0]       pass;
    logic             tx_crc_din;
    logic             rx_crc_din;

    e1crc_slot_decode #(
        .TS_PER_FRAME (TS_PER_FRAME),
        .BITS_PER_TS  (BITS_PER_TS)
    ) i_decode (
        .frame_idx (frame_idx),
        .ts_idx    (ts_idx),
        .bit_idx   (bit_idx),
        .slot_o    (slot)
    );

    e1crc_tx_insert i_tx_insert (
        .is_c      (slot.is_c),
        .c_idx     (slot.c_idx),
        .is_mfa    (slot.is_mfa),
        .mfa_val   (slot.mfa_val),
        .is_si1    (slot.is_si1),
        .is_si2    (slot.is_si2),
        .crc_en    (crc_en),
        .echo_en   (echo_en),
        .tx_in     (tx_in),
        .rem       (tx_rem),
        .rem_valid (tx_rem_valid),
        .pass      (pass),
        .tx_out    (tx_out)
    );

    // Purpose: mask the C positions to zero before each divider.
    always_comb begin
        tx_crc_din = slot.is_c ? 1'b0 : tx_out;
        rx_crc_din = slot.is_c ? 1'b0 : rx_in;
    end

    e1crc_accum i_tx_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (!crc_en),
        .en          (bit_en && crc_en),
        .first       (slot.smf_first),
        .last        (slot.smf_last),
        .din         (tx_crc_din),
        .rem_o       (tx_rem),
        .rem_valid_o (tx_rem_valid)
    );

    e1crc_accum i_rx_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (1'b0),
        .en          (bit_en),
        .first       (slot.smf_first),
        .last        (slot.smf_last),
        .din         (rx_crc_din),
        .rem_o       (rx_rem),
        .rem_valid_o (rx_rem_valid)
    );

    e1crc_rx_check i_rx_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (bit_en),
        .is_c      (slot.is_c),
        .c_idx     (slot.c_idx),
        .smf       (slot.smf),
        .rx_in     (rx_in),
        .rem       (rx_rem),
        .rem_valid (rx_rem_valid),
        .err_o     (rx_err),
        .pass_o    (pass)
    );

    AST_NO_ERR_WITHOUT_C4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_err) |-> $past(bit_en && slot.is_c && slot.c_idx == 2'd3)); // R6
    AST_TX_REM_DROPS_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_en |=> !tx_rem_valid); // R8

endmodule

// File: tb/test_e1_crc4_echo.sv
// Scoreboard bench: the driver computes the expected outputs for each bit and
// queues them; the monitor pops and compares them at the falling edge.
module test_e1_crc4_echo;

    localparam int TSN      = 4;
    localparam int BPT      = 8;
    localparam int SMF_BITS = 8 * TSN * BPT;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic [3:0] frame_idx;
    logic [1:0] ts_idx;
    logic [2:0] bit_idx;
    logic       crc_en;
    logic       echo_en;
    logic       tx_in;
    logic       tx_out;
    logic       rx_in;
    logic [1:0] rx_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       tx;
        logic [1:0] err;
        string      ttag;
        string      etag;
    } sb_item_t;

    sb_item_t sbq[$];

    // reference model state
    bit         tx_bits  [SMF_BITS];
    bit         rx_bits  [SMF_BITS];
    bit         gen_bits [SMF_BITS];
    logic [3:0] t_rem = '0, r_rem = '0, g_rem = '0;
    bit         t_valid = 0, t_started = 0;
    bit         r_valid = 0, r_started = 0;
    bit         g_valid = 0, g_started = 0;
    logic [2:0] r_cbuf = '0;
    logic [1:0] pass_m = 2'b11;
    logic [1:0] pend_err = '0;
    string      pend_tag = "R8";

    always #10 clk = ~clk;

    e1_crc4_echo #(
        .TS_PER_FRAME (TSN),
        .BITS_PER_TS  (BPT)
    ) i_e1_crc4_echo (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .frame_idx (frame_idx),
        .ts_idx    (ts_idx),
        .bit_idx   (bit_idx),
        .crc_en    (crc_en),
        .echo_en   (echo_en),
        .tx_in     (tx_in),
        .tx_out    (tx_out),
        .rx_in     (rx_in),
        .rx_err    (rx_err)
    );

    // Long division by 10011 with four zeros appended.
    function automatic logic [3:0] crc_of(input bit a[SMF_BITS]);
        logic [4:0] r = '0;
        for (int i = 0; i < SMF_BITS + 4; i++) begin
            r = {r[3:0], (i < SMF_BITS) ? a[i] : 1'b0};
            if (r[4]) r = r ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compare the queued expectations with the ports.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            check(it.ttag, {1'b0, tx_out}, {1'b0, it.tx});
            check(it.etag, rx_err, it.err);
        end
    end

    // Driver: one multiframe. fl_smf picks the half to corrupt (-1 none);
    // fl_c corrupts C2 instead of a payload bit.
    task automatic run_mf(input bit cen, input bit een, input int fl_smf, input bit fl_c);
        for (int f = 0; f < 16; f++) begin
            for (int t = 0; t < TSN; t++) begin
                for (int b = 0; b < BPT; b++) begin
                    int k, ci, smf;
                    bit hd, isc, ismfa, si1, si2, rxb, txb, txe, pat;
                    string tt;
                    sb_item_t it;
                    logic [1:0] enew;
                    k     = ((f % 8) * TSN + t) * BPT + b;
                    hd    = (t == 0) && (b == 0);
                    isc   = hd && (f % 2 == 0);
                    ci    = (f % 8) / 2;
                    smf   = f / 8;
                    ismfa = hd && (f % 2 == 1) && (f < 12);
                    si1   = hd && (f == 13);
                    si2   = hd && (f == 15);
                    pat   = (f == 5 || f == 9 || f == 11);
                    // far-end generator with correct check bits
                    if (isc) rxb = g_valid ? g_rem[3 - ci] : 1'b1;
                    else     rxb = 1'($urandom);
                    gen_bits[k] = isc ? 1'b0 : rxb;
                    if (k == 0) g_started = 1;
                    if (k == SMF_BITS - 1 && g_started) begin g_rem = crc_of(gen_bits); g_valid = 1; end
                    if (smf == fl_smf) begin
                        if (!fl_c && k == 37) rxb = ~rxb;
                        if (fl_c && isc && ci == 1) rxb = ~rxb;
                    end
                    txb = 1'($urandom);
                    @(posedge clk);
                    #2;
                    bit_en = 1'b1; frame_idx = 4'(f); ts_idx = 2'(t); bit_idx = 3'(b);
                    crc_en = cen; echo_en = een; tx_in = txb; rx_in = rxb;
                    // expected transmit bit
                    if (isc) begin
                        if (cen) begin tt = t_valid ? "R1" : "R8"; txe = t_valid ? t_rem[3 - ci] : 1'b0; end
                        else     begin tt = "R2"; txe = txb; end
                    end else if (ismfa) begin
                        if (cen) begin tt = "R3"; txe = pat; end
                        else     begin tt = "R2"; txe = txb; end
                    end else if (si1 || si2) begin
                        if (een)      begin tt = "R5"; txe = si1 ? pass_m[0] : pass_m[1]; end
                        else if (cen) begin tt = "R4"; txe = 1'b1; end
                        else          begin tt = "R2"; txe = txb; end
                    end else begin
                        tt = cen ? "R9" : "R2"; txe = txb;
                    end
                    it.tx = txe; it.ttag = tt; it.err = pend_err; it.etag = pend_tag;
                    sbq.push_back(it);
                    // receive model
                    enew = '0;
                    pend_tag = !r_valid ? "R8" : (cen ? "R6" : "R7");
                    if (isc && ci == 3) begin
                        if (r_valid) begin
                            bit mism;
                            mism = ({r_cbuf, rxb} != r_rem);
                            enew[1 - smf]   = mism;
                            pass_m[1 - smf] = !mism;
                        end
                    end else if (isc) begin
                        r_cbuf[2 - ci] = rxb;
                    end
                    pend_err = enew;
                    rx_bits[k] = isc ? 1'b0 : rxb;
                    if (k == 0) r_started = 1;
                    if (k == SMF_BITS - 1 && r_started) begin r_rem = crc_of(rx_bits); r_valid = 1; end
                    // transmit model
                    if (cen) begin
                        tx_bits[k] = isc ? 1'b0 : txe;
                        if (k == 0) t_started = 1;
                        if (k == SMF_BITS - 1 && t_started) begin t_rem = crc_of(tx_bits); t_valid = 1; end
                    end else begin
                        t_started = 0; t_valid = 0;
                    end
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; frame_idx = 4'd13; ts_idx = '0; bit_idx = '0;
        crc_en = 1'b0; echo_en = 1'b1; tx_in = 1'b0; rx_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10", rx_err, 2'b00);
        check("R10", {1'b0, tx_out}, 2'b01);   // frame 13 echo reads pass
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        run_mf(1, 0, -1, 0);   // R8 start-up, R1 R3 R4 R9
        run_mf(1, 0, -1, 0);
        run_mf(1, 1, 0, 0);    // first half fails, R6 err[0]
        run_mf(1, 1, 1, 0);    // R5 echo 0 in frame 13; second half fails
        run_mf(1, 1, -1, 0);   // R5 echo 0 in frame 15, R6 err[1]
        run_mf(1, 1, -1, 0);   // results back to pass
        run_mf(0, 0, 0, 1);    // R2, R7 corrupted C bit flags the second half
        run_mf(0, 1, 1, 0);    // R7 with echo during pass-through
        run_mf(0, 1, -1, 0);
        run_mf(1, 0, -1, 0);   // R8 remainder rebuilt after re-enable
        run_mf(1, 0, -1, 0);
        @(posedge clk);
        #2;
        bit_en = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule